// File: doc/BRIEF.md
# Three-Channel Serial Bus Controller

This block lets software run short transfers on a synchronous serial bus. The bus has a clock line, a host-to-device data line and a device-to-host data line. There are three channels, and each channel has its own set of five 32-bit registers and its own group of device select lines. Software first picks a device through the channel's parameter register. It then fills the immediate data register and writes a command word to the control register. The controller shifts between one and four bytes out of the data register, or into it. When the transfer ends it raises a per-channel completion interrupt.

All channels share one shift engine. Each accepted command joins a small queue, and the engine serves the queue in arrival order. The DMA address and DMA length registers are plain read/write storage. The bus clock runs at a fixed divided rate. The register interface uses 32-bit words. The data register is big-endian toward the wire: bits 31:24 are the first byte sent or received.

Top module: `sbus_ctrl`

## Requirements
- R1: Channel c (c = 0..2) occupies byte offsets 0x14*c + {0x00 parameter, 0x04 DMA address, 0x08 DMA length, 0x0C control, 0x10 data}, with address bits 1:0 ignored. The DMA address, DMA length and data registers read back the last value written. The control register always reads 0, and so does any offset at or above 0x3C. All registers are 0 after reset. Read data is on `bus_rdata` one clock after the request.
- R2: Parameter register layout: bits 2:0 are the device selects (bit d picks device d), bit 4 is completion status and bit 5 is interrupt enable. All other bits read 0. When a write sets more than one select bit, only the lowest set bit is kept.
- R3: Control word layout: bit 0 is start, bit 1 (DMA) is ignored, bits 3:2 give direction (0 = read, 1 = write) and bits 5:4 give the byte count minus one. A start with direction 2 or 3 is ignored. 0x35 is a four-byte write and 0x31 is a four-byte read, and 0x37 acts exactly like 0x35.
- R4: A write transfer of n bytes sends the top 8n bits of the data register on `ser_out`, most significant bit first. `ser_out` changes only while `ser_clk` is low. The data register is left unchanged.
- R5: A read transfer of n bytes samples `ser_in` on each rising `ser_clk` edge. The bits are stored left-aligned: the first byte lands in bits 31:24 and the unreceived low bytes become 0. `ser_out` stays low during a read.
- R6: `ser_clk` idles low. Each transfer gives exactly 8n clock pulses, and each phase lasts HALF system clocks.
- R7: `dev_sel[3*c+d]` is high for the whole of a transfer on channel c with device d selected, and low at all other times. At most one select is ever high.
- R8: A write of a valid start on the same clock edge as cycle T sets the channel's status bit at T+2+16·HALF·n. `irq[c]` (status AND enable, registered) rises one clock later.
- R9: While a channel has a transfer queued or running, control writes and data register writes to that channel are ignored.
- R10: Starts on different channels are served one at a time, in the order their control writes arrived.
- R11: Writing 1 to the parameter status bit clears it, and `irq[c]` falls one clock later. Writing 0 to that bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ser_clk | output | 1 | Serial bus clock |
| ser_out | output | 1 | Host-to-device data |
| ser_in | input | 1 | Device-to-host data |
| dev_sel | output | NCH*NDEV | Active-high device selects, channel-major |
| irq | output | NCH | Per-channel completion interrupt |

## Verification
Read data is due one clock after the read request, so the bench takes it at the falling edge that follows. A completion interrupt is due exactly 16·HALF·n+3 clocks after the control write. The bench counts falling edges from the write and checks that the interrupt first appears at exactly that count. A status clear is due one clock after its write, and the bench checks it one falling edge later. The device model runs on the bus clock edges. Because of that, bit order, pulse count, select timing and received data are all checked independently of the system clock.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int unsigned CH_WORDS = 5;

  localparam logic [2:0] SLOT_PARAM = 3'd0;
  localparam logic [2:0] SLOT_DADDR = 3'd1;
  localparam logic [2:0] SLOT_DLEN  = 3'd2;
  localparam logic [2:0] SLOT_CTRL  = 3'd3;
  localparam logic [2:0] SLOT_DATA  = 3'd4;

  localparam int unsigned PB_STATUS = 4;
  localparam int unsigned PB_IRQEN  = 5;

  localparam int unsigned CB_START   = 0;
  localparam int unsigned CB_DIR_LSB = 2;
  localparam int unsigned CB_LEN_LSB = 4;

  typedef enum logic [1:0] {ENG_IDLE, ENG_LOW, ENG_HIGH} eng_state_t;

  typedef struct packed {
    logic [1:0] len_m1;
    logic       is_write;
  } xfer_cmd_t;
endpackage

// File: rtl/sbus_order_queue.sv
module sbus_order_queue #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned IW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [IW-1:0] push_idx,
  input  logic          pop,
  output logic [IW-1:0] head,
  output logic          empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [IW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);

  // R10: each channel holds at most one entry, so the queue never overfills
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CW'(DEPTH)));
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/sbus_chan_regs.sv
module sbus_chan_regs
  import sbus_pkg::*;
#(
  parameter int unsigned NDEV = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [2:0]      slot,
  input  logic [31:0]     wdata,
  input  logic            done,
  input  logic            done_rd,
  input  logic [31:0]     done_data,
  output logic            start,
  output logic            busy,
  output logic [NDEV-1:0] sel,
  output xfer_cmd_t       cmd,
  output logic [31:0]     data,
  output logic [31:0]     rd_word,
  output logic            irq
);
  logic            status, irq_en;
  logic [31:0]     daddr, dlen;
  logic [NDEV-1:0] sel_req, sel_low;
  logic            dir_ok;

  always_comb begin
    sel_req = wdata[NDEV-1:0];
    sel_low = sel_req & (~sel_req + NDEV'(1));
    dir_ok  = (wdata[CB_DIR_LSB+1:CB_DIR_LSB] == 2'b00) ||
              (wdata[CB_DIR_LSB+1:CB_DIR_LSB] == 2'b01);
    start   = wr_en && (slot == SLOT_CTRL) && wdata[CB_START] && dir_ok && !busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= 1'b0;
      irq_en <= 1'b0;
      sel    <= '0;
      daddr  <= '0;
      dlen   <= '0;
      data   <= '0;
      busy   <= 1'b0;
      cmd    <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_en) begin
        case (slot)
          SLOT_PARAM: begin
            sel    <= sel_low;
            irq_en <= wdata[PB_IRQEN];
            if (wdata[PB_STATUS]) status <= 1'b0;
          end
          SLOT_DADDR: daddr <= wdata;
          SLOT_DLEN:  dlen  <= wdata;
          SLOT_CTRL: begin
            if (start) begin
              busy         <= 1'b1;
              cmd.len_m1   <= wdata[CB_LEN_LSB+1:CB_LEN_LSB];
              cmd.is_write <= wdata[CB_DIR_LSB];
            end
          end
          SLOT_DATA: if (!busy) data <= wdata;
          default: ;
        endcase
      end
      if (done) begin
        busy   <= 1'b0;
        status <= 1'b1;
        if (done_rd) data <= done_data;
      end
      irq <= status && irq_en;
    end
  end

  always_comb begin
    rd_word = '0;
    case (slot)
      SLOT_PARAM: begin
        rd_word[NDEV-1:0] = sel;
        rd_word[PB_STATUS] = status;
        rd_word[PB_IRQEN]  = irq_en;
      end
      SLOT_DADDR: rd_word = daddr;
      SLOT_DLEN:  rd_word = dlen;
      SLOT_DATA:  rd_word = data;
      default:    rd_word = '0;
    endcase
  end

  // R9: a control write while busy leaves the latched command untouched
  p_ctrl_busy_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && slot == SLOT_CTRL) |=> $stable(cmd));
  // R9: data is frozen while the transfer is outstanding
  p_data_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(data));
  // R8: completion from the engine sets the status bit
  p_done_sets_status_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> status);
  // R2: at most one device select stored
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
endmodule

// File: rtl/sbus_shifter.sv
module sbus_shifter
  import sbus_pkg::*;
#(
  parameter int unsigned NCH  = 3,
  parameter int unsigned NDEV = 3,
  parameter int unsigned HALF = 2,
  parameter int unsigned IW   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic [IW-1:0]       chan_idx,
  input  logic [NDEV-1:0]     sel_bits,
  input  logic [31:0]         tx_data,
  input  xfer_cmd_t           cmd,
  input  logic                ser_in,
  output logic                take,
  output logic                ser_clk,
  output logic                ser_out,
  output logic [NCH*NDEV-1:0] dev_sel,
  output logic                done,
  output logic [IW-1:0]       done_chan,
  output logic                done_rd,
  output logic [31:0]         done_data
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  eng_state_t          state;
  logic [CW-1:0]       cnt;
  logic [4:0]          bits_left;
  logic [31:0]         sh_tx, sh_rx;
  logic                cur_rd;
  logic [1:0]          cur_len;
  logic [NCH*NDEV-1:0] sel_place;

  assign take = go && (state == ENG_IDLE);

  always_comb begin
    sel_place = '0;
    for (int c = 0; c < NCH; c++) begin
      if (chan_idx == IW'(c)) sel_place[c*NDEV +: NDEV] = sel_bits;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ENG_IDLE;
      cnt       <= '0;
      bits_left <= '0;
      sh_tx     <= '0;
      sh_rx     <= '0;
      cur_rd    <= 1'b0;
      cur_len   <= '0;
      ser_clk   <= 1'b0;
      ser_out   <= 1'b0;
      dev_sel   <= '0;
      done      <= 1'b0;
      done_chan <= '0;
      done_rd   <= 1'b0;
      done_data <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (take) begin
            state     <= ENG_LOW;
            cnt       <= CW'(HALF - 1);
            bits_left <= {cmd.len_m1, 3'b111};
            sh_tx     <= cmd.is_write ? tx_data : '0;
            ser_out   <= cmd.is_write ? tx_data[31] : 1'b0;
            sh_rx     <= '0;
            cur_rd    <= !cmd.is_write;
            cur_len   <= cmd.len_m1;
            done_chan <= chan_idx;
            dev_sel   <= sel_place;
          end
        end
        ENG_LOW: begin
          if (cnt == '0) begin
            ser_clk <= 1'b1;
            sh_rx   <= {sh_rx[30:0], ser_in};
            state   <= ENG_HIGH;
            cnt     <= CW'(HALF - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ENG_HIGH: begin
          if (cnt == '0) begin
            ser_clk <= 1'b0;
            if (bits_left == '0) begin
              state     <= ENG_IDLE;
              dev_sel   <= '0;
              ser_out   <= 1'b0;
              done      <= 1'b1;
              done_rd   <= cur_rd;
              done_data <= sh_rx << {~cur_len, 3'b000};
            end else begin
              bits_left <= bits_left - 1'b1;
              sh_tx     <= {sh_tx[30:0], 1'b0};
              ser_out   <= sh_tx[30];
              state     <= ENG_LOW;
              cnt       <= CW'(HALF - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_sel));
  p_sel_off_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_IDLE) |-> (dev_sel == '0));
  p_clk_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_IDLE) |-> !ser_clk);
  p_out_moves_low_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(ser_out) |-> !ser_clk);
  p_read_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (state != ENG_IDLE && cur_rd) |-> !ser_out);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
#(
  parameter int unsigned NCH  = 3,
  parameter int unsigned NDEV = 3,
  parameter int unsigned AW   = 8,
  parameter int unsigned HALF = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [AW-1:0]       bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                ser_clk,
  output logic                ser_out,
  input  logic                ser_in,
  output logic [NCH*NDEV-1:0] dev_sel,
  output logic [NCH-1:0]      irq
);
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [31:0]     word_idx;
  logic [NCH-1:0]  hit, start_vec, busy_vec;
  logic [2:0]      slot_arr  [NCH];
  logic [NDEV-1:0] sel_arr   [NCH];
  xfer_cmd_t       cmd_arr   [NCH];
  logic [31:0]     data_arr  [NCH];
  logic [31:0]     rword_arr [NCH];

  logic            push, q_empty, take;
  logic [IW-1:0]   push_idx, head;
  logic [NDEV-1:0] head_sel;
  xfer_cmd_t       head_cmd;
  logic [31:0]     head_data, rd_mux;
  logic            eng_done, eng_done_rd;
  logic [IW-1:0]   eng_done_chan;
  logic [31:0]     eng_done_data;

  assign word_idx = 32'(bus_addr[AW-1:2]);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    localparam int unsigned BASE = c * CH_WORDS;
    assign hit[c]      = bus_sel && (word_idx >= BASE) && (word_idx < BASE + CH_WORDS);
    assign slot_arr[c] = 3'(word_idx - BASE);

    sbus_chan_regs #(.NDEV(NDEV)) i_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (hit[c] && bus_we),
      .slot      (slot_arr[c]),
      .wdata     (bus_wdata),
      .done      (eng_done && (eng_done_chan == IW'(c))),
      .done_rd   (eng_done_rd),
      .done_data (eng_done_data),
      .start     (start_vec[c]),
      .busy      (busy_vec[c]),
      .sel       (sel_arr[c]),
      .cmd       (cmd_arr[c]),
      .data      (data_arr[c]),
      .rd_word   (rword_arr[c]),
      .irq       (irq[c])
    );
  end

  always_comb begin
    push     = |start_vec;
    push_idx = '0;
    rd_mux   = '0;
    head_sel = '0;
    head_cmd = '0;
    head_data = '0;
    for (int c = 0; c < NCH; c++) begin
      if (start_vec[c]) push_idx = IW'(c);
      if (hit[c]) rd_mux = rword_arr[c];
      if (head == IW'(c)) begin
        head_sel  = sel_arr[c];
        head_cmd  = cmd_arr[c];
        head_data = data_arr[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_sel && !bus_we) bus_rdata <= rd_mux;
  end

  sbus_order_queue #(.DEPTH(NCH), .IW(IW)) i_queue (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .push_idx (push_idx),
    .pop      (take),
    .head     (head),
    .empty    (q_empty)
  );

  sbus_shifter #(.NCH(NCH), .NDEV(NDEV), .HALF(HALF), .IW(IW)) i_eng (
    .clk       (clk),
    .rst       (rst),
    .go        (!q_empty),
    .chan_idx  (head),
    .sel_bits  (head_sel),
    .tx_data   (head_data),
    .cmd       (head_cmd),
    .ser_in    (ser_in),
    .take      (take),
    .ser_clk   (ser_clk),
    .ser_out   (ser_out),
    .dev_sel   (dev_sel),
    .done      (eng_done),
    .done_chan (eng_done_chan),
    .done_rd   (eng_done_rd),
    .done_data (eng_done_data)
  );

  // R10: only one start per cycle can enter the queue
  p_one_start_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(start_vec));
  // R9: an accepted start always comes from an idle channel
  p_start_idle_r9: assert property (@(posedge clk) disable iff (rst)
    |(start_vec & busy_vec) == 1'b0);
endmodule

// File: tb/test_sbus_ctrl.sv
module test_sbus_ctrl;
  localparam int unsigned HALF = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ser_clk, ser_out, ser_in;
  logic [8:0]  dev_sel;
  logic [2:0]  irq;

  int vectors = 0;
  int fails   = 0;

  logic [31:0] dev_tx = '0, dev_rx = '0;
  int          dev_nbits = 0;
  logic [8:0]  seen_sel = '0;
  logic [8:0]  order_log [4];
  int          n_log = 0;
  wire         sel_any = |dev_sel;

  always #10 clk = ~clk;

  sbus_ctrl #(.NCH(3), .NDEV(3), .AW(8), .HALF(HALF)) i_sbus_ctrl (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_clk(ser_clk), .ser_out(ser_out),
    .ser_in(ser_in), .dev_sel(dev_sel), .irq(irq)
  );

  assign ser_in = dev_tx[31];

  always @(posedge ser_clk) begin
    dev_rx = {dev_rx[30:0], ser_out};
    dev_nbits = dev_nbits + 1;
    seen_sel = seen_sel | dev_sel;
  end
  always @(negedge ser_clk) dev_tx = dev_tx << 1;
  always @(posedge sel_any) begin
    if (n_log < 4) order_log[n_log] = dev_sel;
    n_log = n_log + 1;
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input int nb, input bit wr, input bit dma);
    return {26'd0, 2'(nb - 1), wr ? 2'b01 : 2'b00, dma, 1'b1};
  endfunction

  task automatic wait_irq(input int c, output int got);
    got = 0;
    for (int k = 1; k <= 600; k++) begin
      @(negedge clk);
      if (irq[c]) begin got = k; break; end
    end
  endtask

  task automatic run_xfer(input int c, input int d, input int nb, input bit wr,
                          input bit dma, input logic [31:0] data, input logic [31:0] dword);
    logic [7:0]  base;
    logic [31:0] rv, mask;
    int got;
    base = 8'(c * 20);
    mask = 32'hFFFF_FFFF << (32 - 8 * nb);
    bus_wr(base, 32'h20 | (32'd1 << d));
    bus_wr(base + 8'h10, data);
    dev_tx = dword; dev_rx = '0; dev_nbits = 0; seen_sel = '0;
    bus_wr(base + 8'h0C, ctrl_word(nb, wr, dma));
    wait_irq(c, got);
    check("R8 irq cycle", 32'(got), 32'(16 * HALF * nb + 3));
    check("R6 pulse count", 32'(dev_nbits), 32'(8 * nb));
    check("R7 select during transfer", 32'(seen_sel), 32'd1 << (c * 3 + d));
    check("R7 select released", 32'(dev_sel), 32'd0);
    bus_rd(base + 8'h10, rv);
    if (wr) begin
      check("R4 bits on wire", dev_rx, data >> (32 - 8 * nb));
      check("R4 data kept", rv, data);
    end else begin
      check("R5 host-out low", dev_rx, 32'd0);
      check("R5 received word", rv, dword & mask);
    end
    bus_rd(base, rv);
    check("R8 status set", rv, 32'h30 | (32'd1 << d));
    bus_wr(base, 32'h20 | (32'd1 << d));
    check("R11 zero keeps status", 32'(irq[c]), 32'd1);
    bus_wr(base, 32'h30 | (32'd1 << d));
    @(negedge clk);
    check("R11 irq cleared", 32'(irq[c]), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
    $finish;
  end

  initial begin
    logic [31:0] rv, a, b;
    int got;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int i = 0; i < 15; i++) begin
      bus_rd(8'(i * 4), rv);
      check("R1 reset value", rv, 32'd0);
    end
    check("R6 clock idle", {29'd0, ser_clk, ser_out, |irq}, 32'd0);
    check("R7 selects idle", 32'(dev_sel), 32'd0);

    // R1: storage registers and read-as-zero
    for (int c = 0; c < 3; c++) begin
      a = $urandom; b = $urandom;
      bus_wr(8'(c * 20 + 4), a);
      bus_wr(8'(c * 20 + 8), b);
      bus_wr(8'(c * 20 + 16), a ^ b);
      bus_rd(8'(c * 20 + 4), rv);  check("R1 DMA address", rv, a);
      bus_rd(8'(c * 20 + 9), rv);  check("R1 DMA length", rv, b);
      bus_rd(8'(c * 20 + 16), rv); check("R1 data", rv, a ^ b);
      bus_rd(8'(c * 20 + 12), rv); check("R1 control reads 0", rv, 32'd0);
    end
    bus_rd(8'h3C, rv); check("R1 unmapped", rv, 32'd0);
    bus_rd(8'hFC, rv); check("R1 unmapped high", rv, 32'd0);

    // R2: parameter layout and lowest select kept
    bus_wr(8'h14, 32'hFFFF_FFFF);
    bus_rd(8'h14, rv); check("R2 param all ones", rv, 32'h21);
    bus_wr(8'h14, 32'h0000_0006);
    bus_rd(8'h14, rv); check("R2 param two selects", rv, 32'h02);

    // R3: directed command codes
    run_xfer(0, 1, 4, 1'b1, 1'b0, 32'hC3A5_0F96, 32'h0);
    run_xfer(0, 1, 4, 1'b0, 1'b0, 32'h0, 32'h9E37_79B9);
    run_xfer(2, 2, 4, 1'b1, 1'b1, 32'h1234_5678, 32'h0);
    run_xfer(1, 0, 1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'hB700_0000);

    // R3: direction code 2 is ignored
    dev_nbits = 0;
    bus_wr(8'h00, 32'h21);
    bus_wr(8'h0C, 32'h39);
    repeat (100) @(negedge clk);
    check("R3 bad direction no pulses", 32'(dev_nbits), 32'd0);
    check("R3 bad direction no irq", 32'(irq[0]), 32'd0);

    // R9: writes while busy are ignored
    bus_wr(8'h14, 32'h21);
    bus_wr(8'h24, 32'hA5C3_1122);
    dev_tx = '0; dev_rx = '0; dev_nbits = 0;
    bus_wr(8'h20, 32'h05);
    bus_wr(8'h20, 32'h31);
    bus_wr(8'h24, 32'h1234_5678);
    wait_irq(1, got);
    repeat (200) @(negedge clk);
    check("R9 single transfer", 32'(dev_nbits), 32'd8);
    check("R9 first command bits", dev_rx, 32'hA5);
    bus_rd(8'h24, rv); check("R9 data write ignored", rv, 32'hA5C3_1122);
    bus_wr(8'h14, 32'h31);

    // R10: service order follows request order
    bus_wr(8'h28, 32'h22);
    bus_wr(8'h00, 32'h24);
    bus_wr(8'h14, 32'h21);
    n_log = 0;
    bus_wr(8'h34, 32'h05);
    bus_wr(8'h0C, 32'h05);
    bus_wr(8'h20, 32'h05);
    repeat (300) @(negedge clk);
    check("R10 transfer count", 32'(n_log), 32'd3);
    check("R10 first", 32'(order_log[0]), 32'h080);
    check("R10 second", 32'(order_log[1]), 32'h004);
    check("R10 third", 32'(order_log[2]), 32'h008);
    check("R8 all irqs", 32'(irq), 32'h7);
    bus_wr(8'h28, 32'h32);
    bus_wr(8'h00, 32'h34);
    bus_wr(8'h14, 32'h31);
    @(negedge clk);
    check("R11 all cleared", 32'(irq), 32'h0);

    // random transfers
    for (int i = 0; i < 24; i++) begin
      run_xfer(int'($urandom % 3), int'($urandom % 3), int'($urandom % 4) + 1,
               1'($urandom), 1'($urandom), $urandom, $urandom);
    end

    report();
    $finish;
  end
endmodule